// File: doc/BRIEF.md
# Four-Channel Byte DMA Engine

This block copies bytes from one memory-mapped location to another on behalf of a set of channels, using a data bus that it shares with a processor. Each channel holds a source and a destination address, a stepping mode for each of them, a burst size and a block length. Software loads a channel by pulsing its start line. After that, every trigger or software request to the channel moves one burst. When the block is finished, the channel switches itself off and raises a one-cycle completion pulse.

A single engine serves all channels. It picks a channel, then alternates a bus read and a bus write for each byte of the burst, and waits for the bus grant before every access. Between bursts, an arbiter chooses the next channel. It uses either a fixed order or a rotating order. A window of addresses holds non-volatile data. The engine may read from this window but must never write into it. A write aimed at the window stops the channel and flags an error.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `bus_req`, every `ch_done` bit and every `ch_err` bit are low.
- R2: A `ch_start` pulse on a channel that is not enabled loads its configuration, enables the channel and clears its error flag. A `ch_start` pulse on a channel that is still enabled changes nothing.
- R3: A `ch_trig` or `ch_swreq` pulse on an enabled channel queues exactly one burst. A request that arrives in the same cycle as the engine accepts the channel's queued request stays queued and produces one more burst. Requests to a channel that is not enabled are dropped.
- R4: Each address mode field is 2 bits. Code 0 adds one to the address after every byte, code 1 subtracts one, and codes 2 and 3 keep the address fixed. The source address steps after each read and the destination address steps after each write.
- R5: A burst field code b (0 to 3) moves 2^b bytes per burst (1, 2, 4 or 8). Each byte is one bus read at the source followed by one bus write of that byte to the destination.
- R6: The 16-bit count field gives the block length in bytes, and a count of 0 means 65536. A burst ends early when the block runs out. In the cycle after the final write is granted, the channel's `ch_done` bit is high for exactly one cycle and the channel is disabled.
- R7: When `rr_mode` is 0, the requesting channel with the lowest index is served next.
- R8: When `rr_mode` is 1, the search for the next channel starts at the channel after the one served last, wrapping around. After reset, the search starts at channel 0.
- R9: Once a burst has started, no other channel gets the bus until that burst ends.
- R10: `bus_req` stays high and `bus_addr`, `bus_we` and `bus_wdata` stay unchanged until `bus_gnt` is high. Read data is taken in the grant cycle, and a write completes in its grant cycle.
- R11: No write is ever issued to an address from NV_LO to NV_HI. A write aimed there aborts the channel instead: `ch_err` goes high and stays high until the next accepted start, and no `ch_done` pulse occurs. Reads from that window are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round-robin |
| ch_start | input | NCH | Per-channel load-and-enable pulse |
| ch_trig | input | NCH | Per-channel hardware trigger |
| ch_swreq | input | NCH | Per-channel software request |
| cfg_src | input | NCH*AW | Source start address, channel i at bits [i*AW +: AW] |
| cfg_dst | input | NCH*AW | Destination start address, same packing |
| cfg_smode | input | 2*NCH | Source address mode, 2 bits per channel |
| cfg_dmode | input | 2*NCH | Destination address mode, 2 bits per channel |
| cfg_burst | input | 2*NCH | Burst size code, 2 bits per channel |
| cfg_count | input | CW*NCH | Block length in bytes, 0 = 65536 |
| ch_done | output | NCH | One-cycle block-complete pulse |
| ch_err | output | NCH | Sticky abort flag |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_gnt | input | 1 | Grant for the current access |
| bus_rdata | input | 8 | Read data, valid in the grant cycle |

## Verification
Two events can fall in the same cycle: a new trigger arriving, and the engine accepting that channel's queued request. When they coincide, the new request must survive. The bench provokes this by holding a trigger high for two consecutive cycles on an idle engine. The second cycle is then exactly the cycle in which the engine takes the request. The bench judges the result by counting the writes and requiring the block-done pulse that only a second burst can produce. The same coincidence is exercised continuously by the priority tests, where triggers are held high for many cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    AM_INC  = 2'd0,
    AM_DEC  = 2'd1,
    AM_FIX  = 2'd2,
    AM_FIX2 = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ES_IDLE = 2'd0,
    ES_RD   = 2'd1,
    ES_WR   = 2'd2
  } est_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_in,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [1:0]    cfg_smode,
  input  logic [1:0]    cfg_dmode,
  input  logic [1:0]    cfg_burst,
  input  logic [CW-1:0] cfg_count,
  input  logic          take,
  input  logic          rd_step,
  input  logic          wr_step,
  input  logic          abort,
  output logic          elig,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          last,
  output logic [3:0]    blen,
  output logic          done,
  output logic          err
);
  localparam int RW = CW + 1;
  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [RW-1:0] R_ONE = RW'(1);

  logic          en, en_d, pend, pend_d, err_d, done_d;
  logic [AW-1:0] src_d, dst_d;
  logic [RW-1:0] rem, rem_d;
  amode_e        smode, dmode;
  logic [1:0]    bsel;
  logic          ld;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input amode_e m);
    case (m)
      AM_INC:  adv = a + A_ONE;
      AM_DEC:  adv = a - A_ONE;
      default: adv = a;
    endcase
  endfunction

  assign ld   = start && !en;          // R2: start only lands on an idle channel
  assign elig = en && pend;
  assign last = (rem == R_ONE);
  assign blen = 4'd1 << bsel;          // R5

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smode <= AM_INC;
      dmode <= AM_INC;
      bsel  <= 2'd0;
    end else if (ld) begin
      smode <= amode_e'(cfg_smode);
      dmode <= amode_e'(cfg_dmode);
      bsel  <= cfg_burst;
    end
  end

  always_comb begin
    en_d   = en;
    pend_d = pend;
    src_d  = src;
    dst_d  = dst;
    rem_d  = rem;
    err_d  = err;
    done_d = 1'b0;
    if (ld) begin
      en_d   = 1'b1;
      pend_d = 1'b0;
      err_d  = 1'b0;
      src_d  = cfg_src;
      dst_d  = cfg_dst;
      rem_d  = (cfg_count == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cfg_count};  // R6
    end else begin
      if (take) pend_d = 1'b0;
      if (req_in && en) pend_d = 1'b1;   // R3: a fresh request outranks the take
      if (rd_step) src_d = adv(src, smode);  // R4
      if (wr_step) begin
        dst_d = adv(dst, dmode);
        rem_d = rem - R_ONE;
        if (last) begin
          en_d   = 1'b0;
          pend_d = 1'b0;
          done_d = 1'b1;
        end
      end
      if (abort) begin                    // R11
        en_d   = 1'b0;
        pend_d = 1'b0;
        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      pend <= 1'b0;
      err  <= 1'b0;
      done <= 1'b0;
      src  <= '0;
      dst  <= '0;
      rem  <= '0;
    end else begin
      en   <= en_d;
      pend <= pend_d;
      err  <= err_d;
      done <= done_d;
      src  <= src_d;
      dst  <= dst_d;
      rem  <= rem_d;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !en);  // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);  // R11
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rr_mode,
  input  logic [NCH-1:0]         req,
  input  logic                   take,
  output logic                   valid,
  output logic [$clog2(NCH)-1:0] idx
);
  localparam int IW = $clog2(NCH);

  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    valid = |req;
    idx   = '0;
    found = 1'b0;
    if (!rr_mode) begin
      for (int i = 0; i < NCH; i++) begin      // R7: lowest index first
        if (!found && req[i]) begin
          idx   = IW'(i);
          found = 1'b1;
        end
      end
    end else begin
      for (int k = 1; k <= NCH; k++) begin     // R8: start after last served
        if (!found && req[(int'(last_q) + k) % NCH]) begin
          idx   = IW'((int'(last_q) + k) % NCH);
          found = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= IW'(NCH - 1);
    else if (take) last_q <= idx;
  end
endmodule

// File: rtl/dma_eng.sv
module dma_eng
  import dma_pkg::*;
#(
  parameter int          NCH   = 4,
  parameter int          AW    = 16,
  parameter int unsigned NV_LO = 32'h1000,
  parameter int unsigned NV_HI = 32'h1FFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arb_valid,
  input  logic [$clog2(NCH)-1:0] arb_idx,
  input  logic [AW-1:0]          src_a,
  input  logic [AW-1:0]          dst_a,
  input  logic                   last,
  input  logic [3:0]             blen,
  input  logic                   bus_gnt,
  input  logic [7:0]             bus_rdata,
  output logic                   take,
  output logic [$clog2(NCH)-1:0] sel,
  output logic                   rd_step,
  output logic                   wr_step,
  output logic                   abort,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [AW-1:0]          bus_addr,
  output logic [7:0]             bus_wdata
);
  localparam logic [AW-1:0] NV_L = AW'(NV_LO);
  localparam logic [AW-1:0] NV_H = AW'(NV_HI);

  est_e       st, st_d;
  logic [2:0] beat, beat_d;
  logic [7:0] data;
  logic       nv_hit, burst_end;

  assign nv_hit    = (dst_a >= NV_L) && (dst_a <= NV_H);
  assign burst_end = (({1'b0, beat} + 4'd1) == blen);
  assign bus_wdata = data;

  always_comb begin
    st_d     = st;
    beat_d   = beat;
    take     = 1'b0;
    rd_step  = 1'b0;
    wr_step  = 1'b0;
    abort    = 1'b0;
    bus_req  = 1'b0;
    bus_we   = 1'b0;
    bus_addr = src_a;
    case (st)
      ES_IDLE: begin
        if (arb_valid) begin
          take   = 1'b1;
          beat_d = '0;
          st_d   = ES_RD;
        end
      end
      ES_RD: begin
        bus_req = 1'b1;                 // R10: hold until granted
        if (bus_gnt) begin
          rd_step = 1'b1;
          st_d    = ES_WR;
        end
      end
      ES_WR: begin
        bus_addr = dst_a;
        if (nv_hit) begin               // R11: drop the write, kill the channel
          abort = 1'b1;
          st_d  = ES_IDLE;
        end else begin
          bus_req = 1'b1;
          bus_we  = 1'b1;
          if (bus_gnt) begin
            wr_step = 1'b1;
            if (last || burst_end) begin
              st_d = ES_IDLE;
            end else begin
              beat_d = beat + 3'd1;
              st_d   = ES_RD;
            end
          end
        end
      end
      default: st_d = ES_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ES_IDLE;
      beat <= '0;
    end else begin
      st   <= st_d;
      beat <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= '0;
    else if (take) sel <= arb_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (rd_step) data <= bus_rdata;
  end

  AST_WAIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));  // R10
  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    st != ES_IDLE |=> st == ES_IDLE || $stable(sel));  // R9
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int          NCH   = 4,
  parameter int          AW    = 16,
  parameter int          CW    = 16,
  parameter int unsigned NV_LO = 32'h1000,
  parameter int unsigned NV_HI = 32'h1FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rr_mode,
  input  logic [NCH-1:0]  ch_start,
  input  logic [NCH-1:0]  ch_trig,
  input  logic [NCH-1:0]  ch_swreq,
  input  logic [NCH*AW-1:0] cfg_src,
  input  logic [NCH*AW-1:0] cfg_dst,
  input  logic [2*NCH-1:0]  cfg_smode,
  input  logic [2*NCH-1:0]  cfg_dmode,
  input  logic [2*NCH-1:0]  cfg_burst,
  input  logic [CW*NCH-1:0] cfg_count,
  output logic [NCH-1:0]  ch_done,
  output logic [NCH-1:0]  ch_err,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [7:0]      bus_wdata,
  input  logic            bus_gnt,
  input  logic [7:0]      bus_rdata
);
  localparam int IW = $clog2(NCH);

  logic [NCH-1:0] elig, last_v, take_v, rd_v, wr_v, ab_v;
  logic [AW-1:0]  src_v [NCH];
  logic [AW-1:0]  dst_v [NCH];
  logic [3:0]     blen_v [NCH];
  logic           arb_valid, eng_take, rd_step, wr_step, abort;
  logic [IW-1:0]  arb_idx, sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign take_v[i] = eng_take && (arb_idx == IW'(i));
    assign rd_v[i]   = rd_step  && (sel == IW'(i));
    assign wr_v[i]   = wr_step  && (sel == IW'(i));
    assign ab_v[i]   = abort    && (sel == IW'(i));

    dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ch_start[i]),
      .req_in    (ch_trig[i] | ch_swreq[i]),
      .cfg_src   (cfg_src[i*AW +: AW]),
      .cfg_dst   (cfg_dst[i*AW +: AW]),
      .cfg_smode (cfg_smode[2*i +: 2]),
      .cfg_dmode (cfg_dmode[2*i +: 2]),
      .cfg_burst (cfg_burst[2*i +: 2]),
      .cfg_count (cfg_count[i*CW +: CW]),
      .take      (take_v[i]),
      .rd_step   (rd_v[i]),
      .wr_step   (wr_v[i]),
      .abort     (ab_v[i]),
      .elig      (elig[i]),
      .src       (src_v[i]),
      .dst       (dst_v[i]),
      .last      (last_v[i]),
      .blen      (blen_v[i]),
      .done      (ch_done[i]),
      .err       (ch_err[i])
    );
  end

  dma_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rr_mode (rr_mode),
    .req     (elig),
    .take    (eng_take),
    .valid   (arb_valid),
    .idx     (arb_idx)
  );

  dma_eng #(.NCH(NCH), .AW(AW), .NV_LO(NV_LO), .NV_HI(NV_HI)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_valid (arb_valid),
    .arb_idx   (arb_idx),
    .src_a     (src_v[sel]),
    .dst_a     (dst_v[sel]),
    .last      (last_v[sel]),
    .blen      (blen_v[sel]),
    .bus_gnt   (bus_gnt),
    .bus_rdata (bus_rdata),
    .take      (eng_take),
    .sel       (sel),
    .rd_step   (rd_step),
    .wr_step   (wr_step),
    .abort     (abort),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  AST_NV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> !((bus_addr >= AW'(NV_LO)) && (bus_addr <= AW'(NV_HI))));  // R11
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_v));  // R7
endmodule

// File: tb/tb_dma_ctrl.sv
module tb_dma_ctrl;
  localparam int CLK_PER = 10;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [7:0]    d;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic rr_mode;
  logic [NCH-1:0] ch_start, ch_trig, ch_swreq;
  logic [NCH*AW-1:0] cfg_src, cfg_dst;
  logic [2*NCH-1:0]  cfg_smode, cfg_dmode, cfg_burst;
  logic [CW*NCH-1:0] cfg_count;
  logic [NCH-1:0] ch_done, ch_err;
  logic bus_req, bus_we, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  logic [7:0] mem [1024];
  item_t expq[$];
  string tagq[$];
  int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;
  int wr_seen = 0;
  int done_cnt [NCH];

  always #(CLK_PER/2) clk = ~clk;

  assign bus_rdata = mem[bus_addr[9:0]];

  dma_ctrl #(.NCH(NCH), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode),
    .ch_start(ch_start), .ch_trig(ch_trig), .ch_swreq(ch_swreq),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_smode(cfg_smode),
    .cfg_dmode(cfg_dmode), .cfg_burst(cfg_burst), .cfg_count(cfg_count),
    .ch_done(ch_done), .ch_err(ch_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata)
  );

  // grant with stalls, changed away from the rising edge
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'h5A;
    bus_gnt = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_gnt = lfsr[0] | lfsr[1];
    end
  end

  // memory model and scoreboard monitor
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 13 + 5) & 255);
    for (int c = 0; c < NCH; c++) done_cnt[c] = 0;
    forever begin
      @(negedge clk);
      #(CLK_PER/4);
      for (int c = 0; c < NCH; c++) if (ch_done[c]) done_cnt[c]++;
      if (bus_req && bus_gnt && bus_we) begin
        item_t e;
        string t;
        wr_seen++;
        mon_checks++;
        if (expq.size() == 0) begin
          mon_errs++;
          $display("FAIL R3 unexpected write actual addr=%0h data=%0h expected none", bus_addr, bus_wdata);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          if (e.a != bus_addr || e.d != bus_wdata) begin
            mon_errs++;
            $display("FAIL %s write actual addr=%0h data=%0h expected addr=%0h data=%0h",
                     t, bus_addr, bus_wdata, e.a, e.d);
          end
        end
        mem[bus_addr[9:0]] = bus_wdata;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL R10 watchdog expired actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errs + mon_errs + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cfg_ch(input int ch, input int s, input int d, input int sm,
                        input int dm, input int b, input int n);
    cfg_src[ch*AW +: AW]   = AW'(s);
    cfg_dst[ch*AW +: AW]   = AW'(d);
    cfg_smode[ch*2 +: 2]   = 2'(sm);
    cfg_dmode[ch*2 +: 2]   = 2'(dm);
    cfg_burst[ch*2 +: 2]   = 2'(b);
    cfg_count[ch*CW +: CW] = CW'(n);
  endtask

  task automatic start_mask(input logic [NCH-1:0] m);
    @(negedge clk);
    ch_start = m;
    @(negedge clk);
    ch_start = '0;
  endtask

  task automatic trig_mask(input logic [NCH-1:0] m, input int ncyc);
    @(negedge clk);
    ch_trig = m;
    repeat (ncyc) @(negedge clk);
    ch_trig = '0;
  endtask

  function automatic int step(input int a, input int m);
    if (m == 0) return a + 1;
    if (m == 1) return a - 1;
    return a;
  endfunction

  // driver: push n expected writes, advancing the caller's addresses
  task automatic push_blk(input string tag, inout int s, inout int d,
                          input int sm, input int dm, input int n);
    for (int i = 0; i < n; i++) begin
      item_t e;
      e.a = AW'(d);
      e.d = mem[s[9:0]];
      expq.push_back(e);
      tagq.push_back(tag);
      s = step(s, sm);
      d = step(d, dm);
    end
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (bus_req) q = 0; else q++;
    end
    #(CLK_PER/2);
  endtask

  initial begin
    int s, d, s2, d2, w0, dn;
    rst_n = 1'b0; rr_mode = 1'b0;
    ch_start = '0; ch_trig = '0; ch_swreq = '0;
    cfg_src = '0; cfg_dst = '0; cfg_smode = '0; cfg_dmode = '0;
    cfg_burst = '0; cfg_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_PER/4);
    // R1: idle after reset
    chk(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
    chk(ch_done == '0, "R1 ch_done", int'(ch_done), 0);
    chk(ch_err == '0, "R1 ch_err", int'(ch_err), 0);

    // R5: 8-byte burst, incrementing both sides
    cfg_ch(0, 'h040, 'h200, 0, 0, 3, 8);
    start_mask(4'b0001);
    s = 'h040; d = 'h200;
    push_blk("R5", s, d, 0, 0, 8);
    trig_mask(4'b0001, 1);
    wait_quiet();
    chk(expq.size() == 0, "R5 burst of 8 written", expq.size(), 0);
    chk(done_cnt[0] == 1, "R6 done after block", done_cnt[0], 1);
    w0 = wr_seen;
    trig_mask(4'b0001, 1);
    wait_quiet();
    chk(wr_seen == w0, "R3 trigger on disabled channel", wr_seen - w0, 0);

    // R4: decrementing source, fixed destination, software request
    cfg_ch(1, 'h0F0, 'h240, 1, 2, 2, 4);
    start_mask(4'b0010);
    s = 'h0F0; d = 'h240;
    push_blk("R4", s, d, 1, 2, 4);
    @(negedge clk); ch_swreq = 4'b0010;
    @(negedge clk); ch_swreq = '0;
    wait_quiet();
    chk(expq.size() == 0, "R4 dec/fixed addressing", expq.size(), 0);
    chk(done_cnt[1] == 1, "R6 done ch1", done_cnt[1], 1);

    // R6: block shorter than burst
    cfg_ch(2, 'h080, 'h260, 0, 1, 3, 3);
    start_mask(4'b0100);
    s = 'h080; d = 'h260;
    push_blk("R6", s, d, 0, 1, 3);
    trig_mask(4'b0100, 1);
    wait_quiet();
    chk(expq.size() == 0, "R6 short block", expq.size(), 0);
    chk(done_cnt[2] == 1, "R6 done ch2", done_cnt[2], 1);

    // R6: block spanning three bursts of 2
    cfg_ch(0, 'h0A0, 'h280, 0, 0, 1, 6);
    start_mask(4'b0001);
    s = 'h0A0; d = 'h280;
    for (int b = 0; b < 3; b++) begin
      push_blk("R6", s, d, 0, 0, 2);
      trig_mask(4'b0001, 1);
      wait_quiet();
      chk(done_cnt[0] == (b == 2 ? 2 : 1), "R6 done only at block end", done_cnt[0], b == 2 ? 2 : 1);
    end
    chk(expq.size() == 0, "R5 two-byte bursts", expq.size(), 0);

    // R3: request in the same cycle as the take survives
    cfg_ch(1, 'h0C0, 'h2A0, 0, 0, 1, 4);
    start_mask(4'b0010);
    s = 'h0C0; d = 'h2A0;
    push_blk("R3", s, d, 0, 0, 4);
    trig_mask(4'b0010, 2);
    wait_quiet();
    chk(expq.size() == 0, "R3 second burst from coincident request", expq.size(), 0);
    chk(done_cnt[1] == 2, "R3 block finished", done_cnt[1], 2);

    // R11: write into the protected window aborts
    cfg_ch(2, 'h0D0, 'h1000, 0, 0, 1, 2);
    start_mask(4'b0100);
    w0 = wr_seen; dn = done_cnt[2];
    trig_mask(4'b0100, 1);
    wait_quiet();
    chk(wr_seen == w0, "R11 no write issued", wr_seen - w0, 0);
    chk(ch_err[2] == 1'b1, "R11 error flag", int'(ch_err[2]), 1);
    chk(done_cnt[2] == dn, "R11 no done on abort", done_cnt[2] - dn, 0);
    // R2: restart clears error; R11: reading the window is allowed
    cfg_ch(2, 'h1000, 'h2C0, 0, 0, 1, 2);
    start_mask(4'b0100);
    #(CLK_PER/4);
    chk(ch_err[2] == 1'b0, "R2 start clears error", int'(ch_err[2]), 0);
    s = 'h1000; d = 'h2C0;
    push_blk("R11", s, d, 0, 0, 2);
    trig_mask(4'b0100, 1);
    wait_quiet();
    chk(expq.size() == 0 && done_cnt[2] == dn + 1, "R11 read from window", expq.size(), 0);

    // R7: fixed priority, ch1 beats ch2 while both keep requesting
    rr_mode = 1'b0;
    cfg_ch(1, 'h100, 'h300, 0, 0, 0, 3);
    cfg_ch(2, 'h110, 'h310, 0, 0, 0, 3);
    start_mask(4'b0110);
    s = 'h100; d = 'h300;
    push_blk("R7", s, d, 0, 0, 3);
    s = 'h110; d = 'h310;
    push_blk("R7", s, d, 0, 0, 3);
    trig_mask(4'b0110, 80);
    wait_quiet();
    chk(expq.size() == 0, "R7 fixed order", expq.size(), 0);

    // R8/R9: round robin, 2-byte bursts kept whole; last served was ch2
    rr_mode = 1'b1;
    cfg_ch(0, 'h120, 'h320, 0, 0, 1, 4);
    cfg_ch(1, 'h130, 'h330, 0, 0, 1, 4);
    start_mask(4'b0011);
    s = 'h120; d = 'h320; s2 = 'h130; d2 = 'h330;
    for (int r = 0; r < 2; r++) begin
      push_blk("R8", s, d, 0, 0, 2);
      push_blk("R9", s2, d2, 0, 0, 2);
    end
    trig_mask(4'b0011, 120);
    wait_quiet();
    chk(expq.size() == 0, "R8 rotation with whole bursts", expq.size(), 0);

    // R2: start on an enabled channel is ignored
    cfg_ch(3, 'h140, 'h340, 0, 0, 1, 2);
    start_mask(4'b1000);
    cfg_ch(3, 'h150, 'h350, 0, 0, 3, 8);
    start_mask(4'b1000);
    s = 'h140; d = 'h340;
    push_blk("R2", s, d, 0, 0, 2);
    trig_mask(4'b1000, 1);
    wait_quiet();
    chk(expq.size() == 0 && done_cnt[3] == 1, "R2 second start ignored", done_cnt[3], 1);

    // R6: count zero means 65536, channel stays enabled after many bursts
    cfg_ch(3, 'h160, 'h360, 0, 0, 3, 0);
    start_mask(4'b1000);
    s = 'h160; d = 'h360;
    for (int b = 0; b < 4; b++) begin
      push_blk("R6", s, d, 0, 0, 8);
      trig_mask(4'b1000, 1);
      wait_quiet();
    end
    chk(expq.size() == 0, "R6 zero count keeps running", expq.size(), 0);
    chk(done_cnt[3] == 1, "R6 no done before 65536", done_cnt[3], 1);

    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
    $finish;
  end
endmodule